// File: doc/BRIEF.md
# Subtract-and-Branch Core with Halt Cell

This block is a one-instruction processor. Every instruction is three bytes A, B and C stored at consecutive addresses starting at the program counter. The core subtracts the byte at address A from the byte at address B and writes the difference back to address B. It then jumps to C if the difference is zero or negative, and otherwise moves on to the next three-byte instruction. The working store is a 32-entry array of 8-bit bytes. Every address is reduced to its low five bits, and program-counter arithmetic wraps modulo 32.

A host fills the store through a byte-wide load port while the core is paused, then raises the run enable. The core steps through a fixed seven-phase sequence over its single internal memory port, one phase per enabled clock. A jump whose target is address 31 (all five bits set) halts the machine. The halted flag rises, the program counter freezes at 31, and the core ignores the run enable until the next reset. The host can read any byte at any time through the same port, which is how results are collected after a halt.

Top module: `subleq_core`

## Requirements
- R1: After reset, `pc` is 0 and `halted` is 0. Reset does not alter the byte store.
- R2: The operands of the instruction at `pc` are A = M[pc], B = M[(pc+1) mod 32] and C = M[(pc+2) mod 32]. Wrap past address 31 continues at address 0.
- R3: The data bytes are read from M[A mod 32] and M[B mod 32]. Only the low five bits of an operand byte select an address.
- R4: The result r = (M[B] − M[A]) mod 256 is written to M[B mod 32]. No other byte changes.
- R5: The branch is taken when r is 0 or r bit 7 is 1. The next `pc` is then C mod 32; otherwise it is (pc+3) mod 32.
- R6: When the next `pc` is 31, `halted` becomes 1 and `pc` reads 31. The store of r from that same instruction still takes effect.
- R7: Once `halted` is 1, the core executes nothing until reset, whatever `run_en` does. `pc` and the store stay unchanged.
- R8: An instruction uses exactly 7 clock edges with `run_en` high. `pc` changes only on the 7th. With `run_en` low the core holds its phase, `pc` and the store, and it resumes where it stopped.
- R9: A host write (`load_en` high) stores `load_data` at `load_addr` only while `run_en` is low, and is ignored while `run_en` is high. `rd_data` always shows M[`load_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Execute one phase per clock while high |
| load_en | input | 1 | Host byte write strobe |
| load_addr | input | 5 | Host byte address (write and read) |
| load_data | input | 8 | Host byte to write |
| rd_data | output | 8 | Byte stored at `load_addr` |
| halted | output | 1 | Sticky halt flag |
| pc | output | 5 | Program counter |

## Verification
The bench targets the cases an implementation most easily gets wrong. Operand bytes of 32 or more must be truncated to five bits; a core that skipped this would address outside the store or wrap wrongly. A program counter of 30 must fetch across the top of the store. A difference of exactly zero must branch, and so must a difference with bit 7 set; a core that compared as unsigned, or tested only the sign, would fall through one of these. A jump to 31 must both store its result and halt; a core that dropped that final store would leave the last byte stale. The bench also pauses in mid-instruction, tries to write from the host while running, and toggles the run enable after a halt. These catch cores that keep advancing, accept a colliding write, or wake up again after halting.

// File: rtl/subleq_pkg.sv
`timescale 1ns/1ps
package subleq_pkg;
  localparam int ADDR_W_DEF = 5;
  localparam int DATA_W_DEF = 8;

  // Execution phases, visited in this order once per instruction.
  typedef enum logic [2:0] {
    PH_FETCH_A  = 3'd0,
    PH_FETCH_B  = 3'd1,
    PH_FETCH_C  = 3'd2,
    PH_LOAD_X   = 3'd3,
    PH_LOAD_Y   = 3'd4,
    PH_STORE    = 3'd5,
    PH_ADVANCE  = 3'd6
  } phase_t;
endpackage

// File: rtl/subleq_mem.sv
`timescale 1ns/1ps
module subleq_mem #(
  parameter int AW = subleq_pkg::ADDR_W_DEF,
  parameter int DW = subleq_pkg::DATA_W_DEF
) (
  input  logic          clk,
  input  logic [AW-1:0] core_addr,
  input  logic          core_we,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  input  logic [AW-1:0] host_addr,
  input  logic          host_we,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // The core store wins; the top keeps the two from ever colliding.
  always_ff @(posedge clk) begin
    if (core_we) begin
      cells[core_addr] <= core_wdata;
    end else if (host_we) begin
      cells[host_addr] <= host_wdata;
    end
  end

  assign core_rdata = cells[core_addr];
  assign host_rdata = cells[host_addr];
endmodule

// File: rtl/subleq_alu.sv
`timescale 1ns/1ps
module subleq_alu #(
  parameter int AW = subleq_pkg::ADDR_W_DEF,
  parameter int DW = subleq_pkg::DATA_W_DEF
) (
  input  logic [DW-1:0] minuend,     // byte read from B
  input  logic [DW-1:0] subtrahend,  // byte read from A
  input  logic [AW-1:0] target,      // C truncated
  input  logic [AW-1:0] cur_pc,
  output logic [DW-1:0] diff,
  output logic          take,
  output logic [AW-1:0] nxt_pc,
  output logic          halt_hit
);
  localparam logic [AW-1:0] HALT_PC = '1;
  localparam logic [AW-1:0] STRIDE  = AW'(3);

  // Two's complement difference: add the inverted subtrahend plus one.
  function automatic logic [DW-1:0] wrap_sub(input logic [DW-1:0] b, input logic [DW-1:0] a);
    return b + ~a + DW'(1);
  endfunction

  // Branch when the result is zero or its sign bit is set.
  function automatic logic leq_zero(input logic [DW-1:0] r);
    return (r == '0) || r[DW-1];
  endfunction

  function automatic logic [AW-1:0] choose_pc(input logic t, input logic [AW-1:0] c,
                                               input logic [AW-1:0] p);
    return t ? c : p + STRIDE;
  endfunction

  always_comb begin
    diff     = wrap_sub(minuend, subtrahend);
    take     = leq_zero(diff);
    nxt_pc   = choose_pc(take, target, cur_pc);
    halt_hit = (nxt_pc == HALT_PC);
  end
endmodule

// File: rtl/subleq_seq.sv
`timescale 1ns/1ps
module subleq_seq #(
  parameter int AW = subleq_pkg::ADDR_W_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic [AW-1:0]        nxt_pc,
  input  logic                 halt_hit,
  output subleq_pkg::phase_t   phase,
  output logic [AW-1:0]        pc,
  output logic                 halted,
  output logic                 step_fire,
  output logic                 store_fire,
  output logic                 advance_fire
);
  import subleq_pkg::*;

  phase_t phase_q, phase_d;

  assign step_fire    = run_en && !halted;
  assign store_fire   = step_fire && (phase_q == PH_STORE);
  assign advance_fire = step_fire && (phase_q == PH_ADVANCE);
  assign phase        = phase_q;

  always_comb begin
    case (phase_q)
      PH_FETCH_A: phase_d = PH_FETCH_B;
      PH_FETCH_B: phase_d = PH_FETCH_C;
      PH_FETCH_C: phase_d = PH_LOAD_X;
      PH_LOAD_X:  phase_d = PH_LOAD_Y;
      PH_LOAD_Y:  phase_d = PH_STORE;
      PH_STORE:   phase_d = PH_ADVANCE;
      default:    phase_d = PH_FETCH_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH_A;
      pc      <= '0;
      halted  <= 1'b0;
    end else if (step_fire) begin
      phase_q <= phase_d;
      if (advance_fire) begin
        pc     <= nxt_pc;
        halted <= halt_hit;
      end
    end
  end
endmodule

// File: rtl/subleq_core.sv
`timescale 1ns/1ps
module subleq_core #(
  parameter int AW = subleq_pkg::ADDR_W_DEF,
  parameter int DW = subleq_pkg::DATA_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] rd_data,
  output logic          halted,
  output logic [AW-1:0] pc
);
  import subleq_pkg::*;

  phase_t        phase;
  logic          step_fire, store_fire, advance_fire;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] op_a, op_b, op_c;
  logic [DW-1:0] val_x, val_y;
  logic [DW-1:0] diff;
  logic          take, halt_hit;
  logic [AW-1:0] nxt_pc;
  logic          host_we;

  assign host_we = load_en && !run_en;

  // One address for the single core port, chosen by phase.
  always_comb begin
    case (phase)
      PH_FETCH_A: mem_addr = pc;
      PH_FETCH_B: mem_addr = pc + AW'(1);
      PH_FETCH_C: mem_addr = pc + AW'(2);
      PH_LOAD_X:  mem_addr = op_a;
      PH_LOAD_Y:  mem_addr = op_b;
      PH_STORE:   mem_addr = op_b;
      default:    mem_addr = pc;
    endcase
  end

  // Operand and data capture; operand bytes keep only their address bits.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_a  <= '0;
      op_b  <= '0;
      op_c  <= '0;
      val_x <= '0;
      val_y <= '0;
    end else if (step_fire) begin
      case (phase)
        PH_FETCH_A: op_a  <= mem_rdata[AW-1:0];
        PH_FETCH_B: op_b  <= mem_rdata[AW-1:0];
        PH_FETCH_C: op_c  <= mem_rdata[AW-1:0];
        PH_LOAD_X:  val_x <= mem_rdata;
        PH_LOAD_Y:  val_y <= mem_rdata;
        default: ;
      endcase
    end
  end

  subleq_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk        (clk),
    .core_addr  (mem_addr),
    .core_we    (store_fire),
    .core_wdata (diff),
    .core_rdata (mem_rdata),
    .host_addr  (load_addr),
    .host_we    (host_we),
    .host_wdata (load_data),
    .host_rdata (rd_data)
  );

  subleq_alu #(.AW(AW), .DW(DW)) alu_i (
    .minuend    (val_y),
    .subtrahend (val_x),
    .target     (op_c),
    .cur_pc     (pc),
    .diff       (diff),
    .take       (take),
    .nxt_pc     (nxt_pc),
    .halt_hit   (halt_hit)
  );

  subleq_seq #(.AW(AW)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .nxt_pc       (nxt_pc),
    .halt_hit     (halt_hit),
    .phase        (phase),
    .pc           (pc),
    .halted       (halted),
    .step_fire    (step_fire),
    .store_fire   (store_fire),
    .advance_fire (advance_fire)
  );

  logic unused_take;
  assign unused_take = take;
endmodule

// File: rtl/subleq_core_chk.sv
`timescale 1ns/1ps
module subleq_core_chk #(
  parameter int AW = subleq_pkg::ADDR_W_DEF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          halted,
  input logic [AW-1:0] pc,
  input logic          store_fire,
  input logic          advance_fire
);
  localparam logic [AW-1:0] HALT_PC = '1;

  // R6
  halt_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (pc == HALT_PC));

  // R6
  halt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(advance_fire));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && !store_fire));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_fire |=> $stable(pc));

  // R8
  idle_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !store_fire);
endmodule

bind subleq_core subleq_core_chk #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_en       (run_en),
  .halted       (halted),
  .pc           (pc),
  .store_fire   (store_fire),
  .advance_fire (advance_fire)
);

// File: tb/subleq_core_tb_top.sv
`timescale 1ns/1ps
module subleq_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       load_en = 1'b0;
  logic [4:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [7:0] rd_data;
  logic       halted;
  logic [4:0] pc;

  int checks = 0;
  int fails  = 0;

  int ref_mem [32];
  int ref_pc;
  bit ref_halt;

  always #5 clk = ~clk;

  subleq_core dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data), .rd_data(rd_data),
    .halted(halted), .pc(pc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference step written from the requirements.
  task automatic ref_step();
    int a, b, c, r, nxt;
    bit t;
    if (ref_halt) return;
    a = ref_mem[ref_pc] % 32;
    b = ref_mem[(ref_pc + 1) % 32] % 32;
    c = ref_mem[(ref_pc + 2) % 32] % 32;
    r = (ref_mem[b] - ref_mem[a] + 256) % 256;
    ref_mem[b] = r;
    t = (r == 0) || (r >= 128);
    nxt = t ? c : (ref_pc + 3) % 32;
    ref_pc = nxt;
    if (nxt == 31) ref_halt = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run_en = 1'b0; load_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ref_pc = 0; ref_halt = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 5'(i); load_data = 8'(ref_mem[i]);
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    load_addr = 5'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic run_cycles(input int n);
    @(negedge clk);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
    run_en = 1'b0;
  endtask

  task automatic cmp_mem(input string req);
    int v;
    for (int i = 0; i < 32; i++) begin
      peek(i, v);
      chk(v == ref_mem[i], req, v, ref_mem[i]);
    end
  endtask

  // Reset, preload, then run instruction by instruction against the model.
  task automatic run_program(input int max_instr);
    do_reset();
    load_all();
    for (int i = 0; i < max_instr && !ref_halt; i++) begin
      ref_step();
      run_cycles(7);
      chk(int'(pc) == ref_pc, "R2 R3 R5 pc", int'(pc), ref_pc);
      chk(halted == ref_halt, "R6 halted", int'(halted), int'(ref_halt));
    end
    cmp_mem("R4 store");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, v2, seed_dummy;
    seed_dummy = $urandom(32'h5b1e);

    // R1 reset state
    do_reset();
    chk(pc == 5'd0, "R1 pc", int'(pc), 0);
    chk(halted == 1'b0, "R1 halted", int'(halted), 0);

    // Demonstration program
    for (int i = 0; i < 32; i++) ref_mem[i] = 0;
    ref_mem[0] = 20; ref_mem[1] = 21; ref_mem[2] = 6;
    ref_mem[3] = 22; ref_mem[4] = 22; ref_mem[5] = 0;
    ref_mem[6] = 31; ref_mem[7] = 31; ref_mem[8] = 31;
    ref_mem[20] = 1; ref_mem[21] = 3; ref_mem[22] = 0;
    load_all();
    ref_step();
    run_cycles(6);
    chk(pc == 5'd0, "R8 pc before 7th edge", int'(pc), 0);
    run_cycles(1);
    chk(int'(pc) == ref_pc, "R8 R5 pc after 7 edges", int'(pc), ref_pc);
    peek(21, v);
    chk(v == 2, "R4 first result", v, 2);
    // Pause in mid-instruction
    run_cycles(3);
    repeat (5) @(negedge clk);
    chk(int'(pc) == ref_pc, "R8 paused pc", int'(pc), ref_pc);
    peek(22, v);
    chk(v == 0, "R8 paused store", v, 0);
    run_cycles(4);
    ref_step();
    chk(int'(pc) == ref_pc, "R8 resumed pc", int'(pc), ref_pc);
    for (int i = 0; i < 20 && !ref_halt; i++) begin
      ref_step();
      run_cycles(7);
      chk(int'(pc) == ref_pc, "R5 pc", int'(pc), ref_pc);
    end
    chk(halted == 1'b1, "R6 halted", int'(halted), 1);
    chk(pc == 5'd31, "R6 pc frozen", int'(pc), 31);
    peek(21, v);
    chk(v == 0, "R6 final M21", v, 0);
    cmp_mem("R4 demo memory");

    // R7 run enable ignored while halted
    run_cycles(20);
    chk(pc == 5'd31, "R7 pc", int'(pc), 31);
    chk(halted == 1'b1, "R7 halted", int'(halted), 1);
    cmp_mem("R7 memory");

    // R9 host write ignored while run_en high
    peek(5, v);
    @(negedge clk);
    run_en = 1'b1; load_en = 1'b1; load_addr = 5'd5; load_data = 8'(~v);
    @(negedge clk);
    run_en = 1'b0; load_en = 1'b0;
    peek(5, v2);
    chk(v2 == v, "R9 write blocked", v2, v);

    // R1 R7 reset releases the halt
    do_reset();
    chk(halted == 1'b0, "R7 halt cleared by reset", int'(halted), 0);
    chk(pc == 5'd0, "R1 pc after reset", int'(pc), 0);
    peek(21, v);
    chk(v == 0, "R1 store kept", v, 0);

    // Wrap across the top of the store and truncated operands
    for (int i = 0; i < 32; i++) ref_mem[i] = 0;
    ref_mem[0] = 40; ref_mem[1] = 41; ref_mem[2] = 30;
    ref_mem[8] = 5;  ref_mem[9] = 5;
    ref_mem[30] = 8'h45; ref_mem[31] = 8'h46;
    ref_mem[5] = 1;  ref_mem[6] = 3;
    run_program(12);

    // Negative difference branches to a truncated all-ones target
    for (int i = 0; i < 32; i++) ref_mem[i] = 0;
    ref_mem[0] = 10; ref_mem[1] = 11; ref_mem[2] = 8'h3F;
    ref_mem[10] = 5; ref_mem[11] = 2;
    run_program(1);
    chk(halted == 1'b1, "R5 R6 negative halt", int'(halted), 1);
    peek(11, v);
    chk(v == 8'hFD, "R4 R6 last store", v, 8'hFD);

    // Random programs
    for (int p = 0; p < 12; p++) begin
      for (int i = 0; i < 32; i++) begin
        if ($urandom_range(3) == 0) ref_mem[i] = int'($urandom_range(255));
        else ref_mem[i] = int'($urandom_range(31));
      end
      run_program(40);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule